// File: doc/BRIEF.md
# Reference PLL Power-Up and Lock Sequencer

This block brings up the PLL that supplies the reference clock to serdes lanes running as root complex. After a start pulse it walks the PLL control pins through a fixed order: supply and regulator on, isolation off, then termination disconnect, clock buffer enable and differential reference select together, then main PLL reset release. A settle wait follows each of the first three steps. After that it samples a lock input at a fixed polling interval. The post-divider leaves reset only once lock has been seen. If no lock arrives within the allowed number of polls, the run ends in error.

All waits are counted in microseconds. A prescaler derives microseconds from a parameter that gives clock cycles per microsecond. A bypass input skips the power-up: the result is then taken directly from an override-status bit driven by another agent. Once finished, the block holds all outputs until the next start pulse it accepts.

Top module: `refpll_bringup_seq`

Let C = CYC_PER_US, S = SETTLE_US*C and P = POLL_US*C. Edge 0 is the clock edge that samples an accepted start.

## Requirements
- R1: While rst_ni is low, iso_o is 1 and pwr_en_o, ldo_en_o, term_disc_o, buf_en_o, ref_sel_o, pll_rstb_o, pdiv_rstb_o, done_o, locked_o and err_o are all 0.
- R2: A start accepted with bypass_i=0 sets pwr_en_o and ldo_en_o to 1 together at edge 0. At the same edge iso_o is 1, every other control output is 0, and done_o, locked_o and err_o are cleared.
- R3: iso_o falls to 0 at edge S and not before, while the supply stays on.
- R4: term_disc_o, buf_en_o and ref_sel_o rise together at edge 2S and not before.
- R5: pll_rstb_o rises at edge 3S and not before.
- R6: lock_i is sampled only at edges 3S+k*P, for k = 1..LOCK_TRIES. At the first such edge that sees lock_i=1, pdiv_rstb_o, done_o and locked_o become 1 and err_o stays 0.
- R7: If lock_i is 0 at all LOCK_TRIES sample edges, then at edge 3S+LOCK_TRIES*P done_o=1, err_o=1 and locked_o=0, and pdiv_rstb_o stays 0.
- R8: pdiv_rstb_o is never 1 unless locked_o and pll_rstb_o are both 1.
- R9: A start accepted with bypass_i=1 gives done_o=1, locked_o=ovr_ok_i and err_o=!ovr_ok_i at edge 0, and returns all control outputs to their R1 values. No power-up step follows.
- R10: Once done_o=1, every output holds its value until the next accepted start, whatever lock_i does.
- R11: A start is accepted only when no sequence is running (after reset or after done_o). A start during a running sequence, with or without bypass, changes no output and no step timing.
- R12: When done_o=1, exactly one of locked_o and err_o is 1. When done_o=0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled each edge |
| bypass_i | input | 1 | Take the result from ovr_ok_i instead of powering up |
| ovr_ok_i | input | 1 | Override status bit 0: 1 means the PLL is already usable |
| lock_i | input | 1 | PLL lock indication |
| pwr_en_o | output | 1 | PLL supply enable |
| ldo_en_o | output | 1 | PLL regulator enable |
| iso_o | output | 1 | Input isolation, 1 = isolated |
| term_disc_o | output | 1 | Termination disconnect |
| buf_en_o | output | 1 | Clock buffer and converter enable |
| ref_sel_o | output | 1 | 1 = differential mux output used as reference |
| pll_rstb_o | output | 1 | Main PLL reset release, 1 = out of reset |
| pdiv_rstb_o | output | 1 | Post-divider reset release, 1 = out of reset |
| done_o | output | 1 | Sequence finished |
| locked_o | output | 1 | Finished with success |
| err_o | output | 1 | Finished with failure |

## Verification
The hardest behaviour to reach from the ports is where lock_i first appears relative to the poll edges: one cycle early or late moves the result to another poll or into the error exit. The bench uses small parameters and sweeps the cycle at which lock rises over every offset from the start edge to past the last poll. For each offset it computes the poll edge that must report success, or the error edge. A second hard case is a start with bypass in the middle of a running sequence. The bench injects it during the supply wait and checks every output on every cycle of that run.

// File: rtl/refpll_seq_pkg.sv
package refpll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWR  = 3'd1,
    ST_ISO  = 3'd2,
    ST_CFG  = 3'd3,
    ST_POLL = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic pwr_on;
    logic ldo_on;
    logic iso;
    logic term_disc;
    logic buf_en;
    logic ref_sel;
    logic pll_rstb;
    logic pdiv_rstb;
  } pll_ctl_t;

  localparam pll_ctl_t CTL_RESET = '{
    pwr_on: 1'b0, ldo_on: 1'b0, iso: 1'b1, term_disc: 1'b0,
    buf_en: 1'b0, ref_sel: 1'b0, pll_rstb: 1'b0, pdiv_rstb: 1'b0
  };

endpackage

// File: rtl/refpll_us_timer.sv
module refpll_us_timer #(
  parameter int CYC_PER_US = 50,
  parameter int UW         = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [UW-1:0] len_us_i,
  output logic          expire_o
);

  logic          run_q;
  logic [UW-1:0] rem_q;
  logic          pre_wrap;
  logic          us_step;

  generate
    if (CYC_PER_US == 1) begin : g_no_pre
      assign pre_wrap = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(CYC_PER_US);
      logic [PW-1:0] pre_q;
      assign pre_wrap = (pre_q == PW'(CYC_PER_US - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          pre_q <= '0;
        else if (load_i)      pre_q <= '0;
        else if (run_q)       pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      end
    end
  endgenerate

  assign us_step  = run_q && pre_wrap;
  assign expire_o = us_step && (rem_q == UW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      rem_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      rem_q <= len_us_i;
    end else if (us_step) begin
      rem_q <= rem_q - 1'b1;
      if (expire_o) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/refpll_seq_fsm.sv
module refpll_seq_fsm
  import refpll_seq_pkg::*;
#(
  parameter int SETTLE_US  = 500,
  parameter int POLL_US    = 1000,
  parameter int LOCK_TRIES = 5,
  parameter int UW         = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bypass_i,
  input  logic          ovr_ok_i,
  input  logic          lock_i,
  input  logic          expire_i,
  output logic          tmr_load_o,
  output logic [UW-1:0] tmr_len_o,
  output pll_ctl_t      ctl_o,
  output logic          done_o,
  output logic          locked_o,
  output logic          err_o,
  output logic          busy_o
);

  localparam int TW = (LOCK_TRIES > 1) ? $clog2(LOCK_TRIES) : 1;

  seq_state_e    state_q;
  pll_ctl_t      ctl_q;
  logic          done_q, locked_q, err_q;
  logic [TW-1:0] tries_q;
  logic          idle_like;
  logic          last_try;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign last_try  = (tries_q == TW'(LOCK_TRIES - 1));
  assign busy_o    = !idle_like;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_len_o  = UW'(SETTLE_US);
    case (state_q)
      ST_IDLE, ST_DONE: tmr_load_o = start_i && !bypass_i;
      ST_PWR, ST_ISO:   tmr_load_o = expire_i;
      ST_CFG: begin
        tmr_load_o = expire_i;
        tmr_len_o  = UW'(POLL_US);
      end
      ST_POLL: begin
        tmr_load_o = expire_i && !lock_i && !last_try;
        tmr_len_o  = UW'(POLL_US);
      end
      default: tmr_load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ctl_q    <= CTL_RESET;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      tries_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            tries_q <= '0;
            if (bypass_i) begin
              ctl_q    <= CTL_RESET;
              done_q   <= 1'b1;
              locked_q <= ovr_ok_i;
              err_q    <= !ovr_ok_i;
              state_q  <= ST_DONE;
            end else begin
              ctl_q        <= CTL_RESET;
              ctl_q.pwr_on <= 1'b1;
              ctl_q.ldo_on <= 1'b1;
              done_q       <= 1'b0;
              locked_q     <= 1'b0;
              err_q        <= 1'b0;
              state_q      <= ST_PWR;
            end
          end
        end
        ST_PWR: begin
          if (expire_i) begin
            ctl_q.iso <= 1'b0;
            state_q   <= ST_ISO;
          end
        end
        ST_ISO: begin
          if (expire_i) begin
            ctl_q.term_disc <= 1'b1;
            ctl_q.buf_en    <= 1'b1;
            ctl_q.ref_sel   <= 1'b1;
            state_q         <= ST_CFG;
          end
        end
        ST_CFG: begin
          if (expire_i) begin
            ctl_q.pll_rstb <= 1'b1;
            tries_q        <= '0;
            state_q        <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (expire_i) begin
            if (lock_i) begin
              ctl_q.pdiv_rstb <= 1'b1;
              done_q          <= 1'b1;
              locked_q        <= 1'b1;
              state_q         <= ST_DONE;
            end else if (last_try) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              tries_q <= tries_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctl_o    = ctl_q;
  assign done_o   = done_q;
  assign locked_o = locked_q;
  assign err_o    = err_q;

endmodule

// File: rtl/refpll_bringup_seq.sv
module refpll_bringup_seq
  import refpll_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int SETTLE_US  = 500,
  parameter int POLL_US    = 1000,
  parameter int LOCK_TRIES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bypass_i,
  input  logic ovr_ok_i,
  input  logic lock_i,
  output logic pwr_en_o,
  output logic ldo_en_o,
  output logic iso_o,
  output logic term_disc_o,
  output logic buf_en_o,
  output logic ref_sel_o,
  output logic pll_rstb_o,
  output logic pdiv_rstb_o,
  output logic done_o,
  output logic locked_o,
  output logic err_o
);

  localparam int MAX_US = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
  localparam int UW     = $clog2(MAX_US + 1);

  logic          tmr_load;
  logic [UW-1:0] tmr_len;
  logic          tmr_expire;
  logic          busy;
  pll_ctl_t      ctl;

  refpll_us_timer #(
    .CYC_PER_US(CYC_PER_US),
    .UW        (UW)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .len_us_i(tmr_len),
    .expire_o(tmr_expire)
  );

  refpll_seq_fsm #(
    .SETTLE_US (SETTLE_US),
    .POLL_US   (POLL_US),
    .LOCK_TRIES(LOCK_TRIES),
    .UW        (UW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bypass_i  (bypass_i),
    .ovr_ok_i  (ovr_ok_i),
    .lock_i    (lock_i),
    .expire_i  (tmr_expire),
    .tmr_load_o(tmr_load),
    .tmr_len_o (tmr_len),
    .ctl_o     (ctl),
    .done_o    (done_o),
    .locked_o  (locked_o),
    .err_o     (err_o),
    .busy_o    (busy)
  );

  assign pwr_en_o    = ctl.pwr_on;
  assign ldo_en_o    = ctl.ldo_on;
  assign iso_o       = ctl.iso;
  assign term_disc_o = ctl.term_disc;
  assign buf_en_o    = ctl.buf_en;
  assign ref_sel_o   = ctl.ref_sel;
  assign pll_rstb_o  = ctl.pll_rstb;
  assign pdiv_rstb_o = ctl.pdiv_rstb;

endmodule

// File: rtl/refpll_bringup_chk.sv
module refpll_bringup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bypass_i,
  input logic ovr_ok_i,
  input logic busy_i,
  input logic pwr_en_i,
  input logic ldo_en_i,
  input logic iso_i,
  input logic term_disc_i,
  input logic buf_en_i,
  input logic ref_sel_i,
  input logic pll_rstb_i,
  input logic pdiv_rstb_i,
  input logic done_i,
  input logic locked_i,
  input logic err_i
);

  p_pwr_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_i == ldo_en_i);

  p_iso_powered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_i |-> pwr_en_i);

  p_cfg_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_disc_i |-> (!iso_i && buf_en_i && ref_sel_i));

  p_rst_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rstb_i |-> (term_disc_i && buf_en_i));

  p_pdiv_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdiv_rstb_i |-> (locked_i && pll_rstb_i));

  p_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bypass_i && !busy_i) |=>
      (done_i && (locked_i == $past(ovr_ok_i)) && !pwr_en_i && iso_i && !pll_rstb_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=>
      $stable({pwr_en_i, ldo_en_i, iso_i, term_disc_i, buf_en_i, ref_sel_i,
               pll_rstb_i, pdiv_rstb_i, done_i, locked_i, err_i}));

  p_busy_no_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> (busy_i || done_i));

  p_outcome_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i ? $onehot({locked_i, err_i}) : !(locked_i || err_i));

endmodule

bind refpll_bringup_seq refpll_bringup_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bypass_i   (bypass_i),
  .ovr_ok_i   (ovr_ok_i),
  .busy_i     (busy),
  .pwr_en_i   (pwr_en_o),
  .ldo_en_i   (ldo_en_o),
  .iso_i      (iso_o),
  .term_disc_i(term_disc_o),
  .buf_en_i   (buf_en_o),
  .ref_sel_i  (ref_sel_o),
  .pll_rstb_i (pll_rstb_o),
  .pdiv_rstb_i(pdiv_rstb_o),
  .done_i     (done_o),
  .locked_i   (locked_o),
  .err_i      (err_o)
);

// File: tb/refpll_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module refpll_bringup_seq_tb_top;

  localparam int CYC  = 2;
  localparam int SET  = 3;
  localparam int POL  = 4;
  localparam int TRY  = 3;
  localparam int S    = CYC * SET;
  localparam int P    = CYC * POL;
  localparam int LAST = 3 * S + TRY * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bypass = 1'b0, ovr = 1'b0, lock = 1'b0;
  logic pwr, ldo, iso, term, bufe, rsel, pllr, pdiv, done, locked, err;

  int checks = 0;
  int fails  = 0;
  bit over   = 1'b0;

  always #10 clk = ~clk;

  refpll_bringup_seq #(
    .CYC_PER_US(CYC), .SETTLE_US(SET), .POLL_US(POL), .LOCK_TRIES(TRY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bypass_i(bypass),
    .ovr_ok_i(ovr), .lock_i(lock),
    .pwr_en_o(pwr), .ldo_en_o(ldo), .iso_o(iso), .term_disc_o(term),
    .buf_en_o(bufe), .ref_sel_o(rsel), .pll_rstb_o(pllr), .pdiv_rstb_o(pdiv),
    .done_o(done), .locked_o(locked), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic hold_check(input int cycles);
    logic [10:0] snap;
    snap = {pwr, ldo, iso, term, bufe, rsel, pllr, pdiv, done, locked, err};
    for (int i = 0; i < cycles; i++) begin
      lock = ~lock;
      @(negedge clk);
    end
    chk_eq("R10", "outputs held after done", int'({pwr, ldo, iso, term, bufe, rsel, pllr, pdiv, done, locked, err}), int'(snap));
  endtask

  task automatic run_seq(input int lk_at, input bit full, input bit poke);
    int  exp_m;
    bit  exp_ok;
    bit  found;
    int  m;
    bit  seen;
    exp_m = LAST; exp_ok = 1'b0; found = 1'b0;
    for (int k = 1; k <= TRY; k++) begin
      if (!found && (3 * S + k * P > lk_at)) begin
        exp_m = 3 * S + k * P; exp_ok = 1'b1; found = 1'b1;
      end
    end
    lock = 1'b0; bypass = 1'b0;
    pulse_start();
    chk_eq("R2", "done cleared at start", int'(done), 0);
    chk_eq("R2", "supply on at start", int'(pwr & ldo), 1);
    m = 0; seen = 1'b0;
    while (!seen && m <= LAST + 4) begin
      if (m == lk_at) lock = 1'b1;
      if (poke) begin
        if (m == 3) begin start = 1'b1; bypass = 1'b1; ovr = 1'b1; end
        if (m == 4) begin start = 1'b0; bypass = 1'b0; end
      end
      if (full) begin
        chk_eq("R2", "pwr/ldo", int'({pwr, ldo}), 3);
        chk_eq("R3", "iso", int'(iso), int'(m < S));
        chk_eq("R4", "term/buf/ref", int'({term, bufe, rsel}), (m >= 2 * S) ? 7 : 0);
        chk_eq("R5", "pll reset release", int'(pllr), int'(m >= 3 * S));
        if (poke) chk_eq("R11", "done during busy", int'(done), int'(m >= exp_m));
      end
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        m++;
      end
    end
    chk_eq(exp_ok ? "R6" : "R7", "done edge", m, exp_m);
    chk_eq("R6", "locked", int'(locked), int'(exp_ok));
    chk_eq("R7", "err", int'(err), int'(!exp_ok));
    chk_eq("R8", "post-divider release", int'(pdiv), int'(exp_ok));
    chk_eq("R12", "one outcome", int'(locked) + int'(err), 1);
    hold_check(12);
  endtask

  task automatic run_bypass(input bit v);
    ovr = v; bypass = 1'b1;
    pulse_start();
    bypass = 1'b0;
    chk_eq("R9", "bypass done", int'(done), 1);
    chk_eq("R9", "bypass locked", int'(locked), int'(v));
    chk_eq("R9", "bypass err", int'(err), int'(!v));
    chk_eq("R9", "controls at reset values",
           int'({pwr, ldo, iso, term, bufe, rsel, pllr, pdiv}), 8'b0010_0000);
    hold_check(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_eq("R1", "controls in reset", int'({pwr, ldo, iso, term, bufe, rsel, pllr, pdiv}), 8'b0010_0000);
    chk_eq("R1", "status in reset", int'({done, locked, err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1", "idle after reset", int'({pwr, iso, done}), 3'b010);

    run_seq(10, 1'b1, 1'b0);
    run_seq(LAST + 8, 1'b1, 1'b1);
    for (int l = 0; l <= LAST + 2; l++) run_seq(l, 1'b0, 1'b0);

    run_bypass(1'b1);
    run_bypass(1'b0);
    run_seq(20, 1'b0, 1'b0);
    run_bypass(1'b0);
    run_bypass(1'b1);
    run_seq(LAST + 5, 1'b0, 1'b0);
    run_bypass(1'b1);
    run_seq(3 * S + P, 1'b1, 1'b0);

    over = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      over = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule